// File: doc/BRIEF.md
# Accumulator Store Rounding and Clamping

This block turns a wide signed accumulator value into the single 1.15 fractional word that is written to memory. It picks the middle word of the accumulator, and it can round that word from the discarded low word first. There are two rounding rules. The biased rule always rounds a half upward. The unbiased rule breaks an exact half towards an even result.

After rounding, an optional clamp limits the word to the 1.15 range. The clamp takes the sign from the top bit of the source accumulator. It judges the magnitude from the rounded value, so a carry out of the rounding step is caught as well. The source accumulator is only read, never changed. The result sits in an output register that is loaded on every clock edge.

The accumulator width, the stored word width and the width of the discarded low word are parameters. Defaults are 40, 16 and 16, giving 8 guard bits.

Top module: `acc_store_fmt`

## Requirements
- R1: With the round request low and the clamp off, the stored word is accumulator bits 31 down to 16. Bits 15 down to 0 have no effect.
- R2: With the round request high and mode 0 (biased), the stored word is the high word plus one when accumulator bit 15 is 1. Otherwise it is the high word unchanged.
- R3: With the round request high and mode 1 (unbiased), the behaviour matches R2, except when bits 15..0 are exactly 0x8000. In that case the word is incremented only if accumulator bit 16 is 1.
- R4: The mode input has no effect on the output while the round request is low.
- R5: With the clamp on and accumulator bit 39 equal to 0, a rounded value whose bits 39..16 exceed 0x007FFF stores 0x7FFF.
- R6: With the clamp on and accumulator bit 39 equal to 1, a rounded value whose bits 39..16 lie below 0xFF8000 (signed) stores 0x8000.
- R7: The clamp judges the value after rounding. A positive value whose rounding carry passes 0x7FFF stores 0x7FFF.
- R8: With the clamp off, the low 16 bits of the rounded or truncated high word pass through even when the guard bits hold other data.
- R9: With the clamp on, an in-range rounded value is stored unchanged.
- R10: The output register holds 0x0000 after a synchronous reset. Otherwise it shows the result for the inputs present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 40 | Source accumulator value (two's complement) |
| rnd_req_i | input | 1 | 1 = round, 0 = truncate |
| rnd_mode_i | input | 1 | 0 = biased rounding, 1 = unbiased rounding |
| sat_en_i | input | 1 | 1 = clamp the stored word to the 1.15 range |
| word_o | output | 16 | Registered 1.15 word |

## Verification
There is no state apart from the output register, so a wrong decision always shows up in word_o one edge after the inputs are applied. It never hides across cycles. An error in the tie rule appears only when the low word is exactly 0x8000, split by the parity of bit 16. An error in clamp ordering appears only for values at the edge of the range, where the rounding carry crosses 0x7FFF or the guard bits disagree with bit 31. The sweep therefore combines boundary values in the guard byte, the high word and the low word, and checks every combination under each control setting on the very next cycle.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
  typedef enum logic {
    RND_BIASED   = 1'b0,
    RND_UNBIASED = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/acc_rounder.sv
module acc_rounder
  import acc_store_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             rnd_req_i,
  input  rnd_mode_e        mode_i,
  output logic [ACC_W-1:0] rounded_o
);
  localparam int LOW_TOP = FRAC_W - 1;

  logic half_set;
  logic exact_half;
  logic high_odd;
  logic bump;

  assign half_set   = acc_i[LOW_TOP];
  assign exact_half = half_set && (acc_i[LOW_TOP-1:0] == '0);
  assign high_odd   = acc_i[FRAC_W];

  always_comb begin
    bump = 1'b0;
    if (rnd_req_i) begin
      if (mode_i == RND_BIASED) bump = half_set;
      else                      bump = half_set && (!exact_half || high_odd);
    end
  end

  // Increment lands on the LSB of the stored word; wraps within ACC_W bits.
  assign rounded_o = acc_i + ({{(ACC_W-1){1'b0}}, bump} << FRAC_W);
endmodule

// File: rtl/store_clamp.sv
module store_clamp #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16,
  parameter int FRAC_W = 16
) (
  input  logic [ACC_W-1:0]  rounded_i,
  input  logic              src_sign_i,
  input  logic              sat_en_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HI_LSB = FRAC_W;
  localparam int HI_MSB = FRAC_W + WORD_W - 1;

  logic pos_over;
  logic neg_over;
  logic [WORD_W-1:0] raw_word;

  assign raw_word = rounded_i[HI_MSB:HI_LSB];
  // Positive source: any set bit from the word sign up to bit ACC_W-1 is too big.
  assign pos_over = !src_sign_i && (|rounded_i[ACC_W-1:HI_MSB]);
  // Negative source: still negative after rounding yet not a pure sign extension.
  assign neg_over = src_sign_i && rounded_i[ACC_W-1] && !(&rounded_i[ACC_W-2:HI_MSB]);

  always_comb begin
    word_o = raw_word;
    if (sat_en_i) begin
      if (pos_over)      word_o = {1'b0, {(WORD_W-1){1'b1}}};
      else if (neg_over) word_o = {1'b1, {(WORD_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/acc_store_fmt.sv
module acc_store_fmt
  import acc_store_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              rnd_req_i,
  input  logic              rnd_mode_i,
  input  logic              sat_en_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HI_LSB = FRAC_W;
  localparam int HI_MSB = FRAC_W + WORD_W - 1;

  logic [ACC_W-1:0]  rounded;
  logic [WORD_W-1:0] word_next;
  rnd_mode_e         mode;

  assign mode = rnd_mode_e'(rnd_mode_i);

  acc_rounder #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_round (
    .acc_i    (acc_i),
    .rnd_req_i(rnd_req_i),
    .mode_i   (mode),
    .rounded_o(rounded)
  );

  store_clamp #(.ACC_W(ACC_W), .WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_clamp (
    .rounded_i (rounded),
    .src_sign_i(acc_i[ACC_W-1]),
    .sat_en_i  (sat_en_i),
    .word_o    (word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= word_next;
  end

  p_reset_r10: assert property (@(posedge clk) rst |=> word_o == '0);

  p_trunc_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !rnd_req_i && !sat_en_i) |-> word_o == $past(acc_i[HI_MSB:HI_LSB]));

  p_biased_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && rnd_req_i && !rnd_mode_i && !sat_en_i)
      |-> word_o == WORD_W'($past(acc_i[HI_MSB:HI_LSB]) + $past(acc_i[FRAC_W-1])));

  p_pos_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && sat_en_i && !acc_i[ACC_W-1]) |-> !word_o[WORD_W-1]);

  p_neg_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && sat_en_i && acc_i[ACC_W-1]) |-> (word_o[WORD_W-1] || word_o == '0));
endmodule

// File: tb/acc_store_fmt_tb.sv
module acc_store_fmt_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] acc_i = '0;
  logic        rnd_req_i = 1'b0;
  logic        rnd_mode_i = 1'b0;
  logic        sat_en_i = 1'b0;
  logic [15:0] word_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_store_fmt u_dut (
    .clk(clk), .rst(rst), .acc_i(acc_i), .rnd_req_i(rnd_req_i),
    .rnd_mode_i(rnd_mode_i), .sat_en_i(sat_en_i), .word_o(word_o)
  );

  function automatic logic [15:0] model(logic [39:0] a, bit rq, bit md, bit st);
    longint s, hi, lo, r;
    bit inc;
    s  = a[39] ? (longint'(a) - (longint'(1) << 40)) : longint'(a);
    hi = s >>> 16;
    lo = s & 64'hFFFF;
    inc = 1'b0;
    if (rq) begin
      if (!md) inc = (lo >= 64'h8000);
      else if (lo == 64'h8000) inc = hi[0];
      else inc = (lo > 64'h8000);
    end
    r = hi + longint'(inc);
    if (st && r > 32767)  return 16'h7FFF;
    if (st && r < -32768) return 16'h8000;
    return r[15:0];
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s acc=%h req=%0b mode=%0b sat=%0b actual=%h expected=%h",
               req, acc_i, rnd_req_i, rnd_mode_i, sat_en_i, got, exp);
    end
  endtask

  function automatic string tag_of(logic [39:0] a, bit rq, bit md, bit st, logic [15:0] e);
    longint s, hi;
    s  = a[39] ? (longint'(a) - (longint'(1) << 40)) : longint'(a);
    hi = s >>> 16;
    if (st && e == 16'h7FFF && hi == 32767 && rq) return "R7";
    if (st && e == 16'h7FFF && hi > 32767) return "R5";
    if (st && e == 16'h8000 && hi < -32768) return "R6";
    if (st) return "R9";
    if (hi > 32767 || hi < -32768) return "R8";
    if (!rq) return md ? "R4" : "R1";
    if (a[15:0] == 16'h8000 && md) return "R3";
    return md ? "R3" : "R2";
  endfunction

  task automatic apply(logic [39:0] a, bit rq, bit md, bit st, string req);
    @(negedge clk);
    acc_i = a; rnd_req_i = rq; rnd_mode_i = md; sat_en_i = st;
    @(negedge clk);
    check(req, word_o, model(a, rq, md, st));
  endtask

  initial begin
    logic [7:0]  gv[6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    logic [15:0] hv[6] = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF, 16'h8000, 16'hFFFF};
    logic [15:0] lv[6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
    logic [39:0] a;
    repeat (3) @(negedge clk);
    check("R10", word_o, 16'h0000);
    rst = 1'b0;
    // Directed corners
    apply(40'h00_1234_8000, 1'b1, 1'b1, 1'b0, "R3");
    check("R3", word_o, 16'h1234);
    apply(40'h00_1235_8000, 1'b1, 1'b1, 1'b0, "R3");
    check("R3", word_o, 16'h1236);
    apply(40'h00_1234_8000, 1'b1, 1'b0, 1'b0, "R2");
    check("R2", word_o, 16'h1235);
    apply(40'h00_7FFF_8000, 1'b1, 1'b0, 1'b1, "R7");
    check("R7", word_o, 16'h7FFF);
    apply(40'hFF_FFFF_8000, 1'b1, 1'b0, 1'b1, "R9");
    check("R9", word_o, 16'h0000);
    apply(40'h7F_FFFF_8000, 1'b1, 1'b0, 1'b1, "R5");
    check("R5", word_o, 16'h7FFF);
    apply(40'h80_0000_0000, 1'b0, 1'b0, 1'b1, "R6");
    check("R6", word_o, 16'h8000);
    apply(40'h12_ABCD_FFFF, 1'b0, 1'b1, 1'b0, "R4");
    check("R4", word_o, 16'hABCD);
    // Sweep
    for (int g = 0; g < 6; g++)
      for (int h = 0; h < 6; h++)
        for (int l = 0; l < 6; l++)
          for (int c = 0; c < 8; c++) begin
            a = {gv[g], hv[h], lv[l]};
            apply(a, c[0], c[1], c[2],
                  tag_of(a, c[0], c[1], c[2], model(a, c[0], c[1], c[2])));
          end
    // Reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10", word_o, 16'h0000);
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule